// File: doc/BRIEF.md
# Push-Button LED Position Stepper

This block drives a bar of LEDs on which exactly one LED is lit. Two push buttons move the lit position one place at a time: one button moves it toward bit 0, the other toward the top bit. Both buttons and the reset request are active-low and arrive with no timing relation to the system clock. Each one passes through a two-register synchronizer before any logic uses it, so everything downstream runs in one clock domain.

A step happens only when a synchronized button value falls from 1 to 0. A button held down therefore gives one step, and releasing it gives none. Switch bounce is outside this block's scope, and the inputs are treated as clean once synchronized. Reset loads a fixed pattern with a single lit bit. A step that would push the lit bit off either end of the bar is refused, so the bar is never dark.

Top module: `led_stepper`

## Requirements
- R1: Each asynchronous input passes through two clocked stages. A button level applied between rising edges k-1 and k moves the LED output at edge k+2. The output keeps its old value after edges k and k+1.
- R2: While the synchronized reset is low, the output is loaded with 8'b0001_0000 (bit 4 lit, for the default width of 8) on each rising edge.
- R3: A falling edge on `step_down_n` (the synchronized value goes from 1 to 0) shifts the pattern one place toward bit 0.
- R4: A falling edge on `step_up_n` shifts the pattern one place toward the most significant bit.
- R5: When both buttons produce a falling edge on the same cycle, the pattern holds.
- R6: A button held low for many cycles gives exactly one step. A rising edge on a button has no effect.
- R7: A shift toward bit 0 while bit 0 is lit is refused, and so is a shift toward the top bit while the top bit is lit. The pattern holds in both cases.
- R8: A synchronized reset takes priority over any button event on the same cycle.
- R9: After the first reset, exactly one output bit is set on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. All registers update on its rising edge. |
| step_down_n | input | 1 | Asynchronous active-low button that moves the lit LED toward bit 0. |
| step_up_n | input | 1 | Asynchronous active-low button that moves the lit LED toward the top bit. |
| rst_req_n | input | 1 | Asynchronous active-low reset request. |
| leds | output | W | Registered LED bar pattern. |

## Verification
The checker watches these behaviours on every clock:
- the reset load and reset priority;
- one-hot output;
- single-place shifts in each direction;
- holding when both buttons or neither button produce an event;
- refusal at each end of the bar.

The checker takes its events from the synchronizer registers. It therefore cannot show the latency from a pin to the output, and it cannot show that a long press or a release leaves the bar alone. The bench's directed scenarios cover those points:
- exact edge counts after a press;
- long holds and releases;
- presses that arrive together;
- a reset that arrives with a press.

In all of these, the bench compares the output each cycle against a model built on input history queues.

// File: rtl/led_stepper.sv
module led_stepper #(
  parameter int W    = 8,
  parameter int HOME = 4
) (
  input  logic         clk,
  input  logic         step_down_n,
  input  logic         step_up_n,
  input  logic         rst_req_n,
  output logic [W-1:0] leds
);

  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] HOME_PAT = ONE << HOME;

  logic [2:0] dn_pipe;
  logic [2:0] up_pipe;
  logic [1:0] rs_pipe;

  always_ff @(posedge clk) begin
    dn_pipe <= {dn_pipe[1:0], step_down_n};
    up_pipe <= {up_pipe[1:0], step_up_n};
    rs_pipe <= {rs_pipe[0], rst_req_n};
  end

  logic dn_fall, up_fall;
  assign dn_fall = dn_pipe[2] & ~dn_pipe[1];
  assign up_fall = up_pipe[2] & ~up_pipe[1];

  always_ff @(posedge clk) begin
    if (!rs_pipe[1])
      leds <= HOME_PAT;
    else begin
      case ({dn_fall, up_fall})
        2'b10: if (!leds[0])   leds <= leds >> 1;
        2'b01: if (!leds[W-1]) leds <= leds << 1;
        default: leds <= leds;
      endcase
    end
  end

endmodule

// File: rtl/led_stepper_chk.sv
module led_stepper_chk #(
  parameter int W    = 8,
  parameter int HOME = 4
) (
  input logic         clk,
  input logic         rs_sync,
  input logic [1:0]   dn_s,
  input logic [1:0]   up_s,
  input logic [W-1:0] leds
);

  localparam logic [W-1:0] HOME_PAT = {{(W-1){1'b0}}, 1'b1} << HOME;

  logic armed = 1'b0;
  always_ff @(posedge clk)
    if (rs_sync === 1'b0) armed <= 1'b1;

  logic dn_ev, up_ev;
  assign dn_ev = dn_s[1] & ~dn_s[0];
  assign up_ev = up_s[1] & ~up_s[0];

  a_r2_reset_load: assert property (@(posedge clk) disable iff (!armed)
    !rs_sync |=> leds == HOME_PAT);

  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!armed)
    (!rs_sync && (dn_ev || up_ev)) |=> leds == HOME_PAT);

  a_r9_onehot: assert property (@(posedge clk) disable iff (!armed)
    $countones(leds) == 1);

  a_r3_down_shift: assert property (@(posedge clk) disable iff (!armed)
    (rs_sync && dn_ev && !up_ev && !leds[0]) |=> leds == ($past(leds) >> 1));

  a_r4_up_shift: assert property (@(posedge clk) disable iff (!armed)
    (rs_sync && up_ev && !dn_ev && !leds[W-1]) |=> leds == ($past(leds) << 1));

  a_r5_both_hold: assert property (@(posedge clk) disable iff (!armed)
    (rs_sync && up_ev && dn_ev) |=> $stable(leds));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!armed)
    (rs_sync && !up_ev && !dn_ev) |=> $stable(leds));

  a_r7_low_end: assert property (@(posedge clk) disable iff (!armed)
    (rs_sync && dn_ev && leds[0]) |=> $stable(leds));

  a_r7_high_end: assert property (@(posedge clk) disable iff (!armed)
    (rs_sync && up_ev && leds[W-1]) |=> $stable(leds));

endmodule

bind led_stepper led_stepper_chk #(.W(W), .HOME(HOME)) i_chk (
  .clk     (clk),
  .rs_sync (rs_pipe[1]),
  .dn_s    (dn_pipe[2:1]),
  .up_s    (up_pipe[2:1]),
  .leds    (leds)
);

// File: tb/test_led_stepper.sv
module test_led_stepper;

  logic       clk = 1'b0;
  logic       dn_n = 1'b1, up_n = 1'b1, rst_n = 1'b0;
  logic [7:0] leds;

  always #2 clk = ~clk;

  led_stepper i_led_stepper (
    .clk(clk), .step_down_n(dn_n), .step_up_n(up_n),
    .rst_req_n(rst_n), .leds(leds)
  );

  int vectors = 0, fails = 0, edges = 0;
  bit done = 0;
  string cur_req = "R2";

  int q_dn[$], q_up[$], q_rs[$];
  int model = 16;

  always @(posedge clk) begin
    edges++;
    if (q_rs.size() >= 2 && q_dn.size() >= 3 && q_up.size() >= 3) begin
      bit dev, uev;
      dev = (q_dn[2] == 1) && (q_dn[1] == 0);
      uev = (q_up[2] == 1) && (q_up[1] == 0);
      if (q_rs[1] == 0) model = 16;
      else if (dev && !uev) begin
        if (model != 1) model = model / 2;
      end else if (uev && !dev) begin
        if (model != 128) model = model * 2;
      end
    end
    q_dn.push_front(int'(dn_n));
    q_up.push_front(int'(up_n));
    q_rs.push_front(int'(rst_n));
    if (q_dn.size() > 3) void'(q_dn.pop_back());
    if (q_up.size() > 3) void'(q_up.pop_back());
    if (q_rs.size() > 3) void'(q_rs.pop_back());
  end

  always @(negedge clk) begin
    if (edges >= 5 && !done) begin
      vectors++;
      if (leds !== 8'(model)) begin
        fails++;
        $display("FAIL %s: model compare leds=%b expected=%b", cur_req, leds, 8'(model));
      end
      vectors++;
      if ($countones(leds) != 1) begin
        fails++;
        $display("FAIL R9: leds=%b expected one bit set", leds);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] exp);
    vectors++;
    if (leds !== exp) begin
      fails++;
      $display("FAIL %s: leds=%b expected=%b", req, leds, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit d, input bit u, input int hold);
    @(negedge clk); #0.5;
    if (d) dn_n = 1'b0;
    if (u) up_n = 1'b0;
    cyc(hold);
    #0.5;
    dn_n = 1'b1; up_n = 1'b1;
    cyc(6);
  endtask

  initial begin
    cyc(8);
    cur_req = "R2";
    check("R2", 8'b0001_0000);
    #0.5 rst_n = 1'b1;
    cyc(6);
    check("R2", 8'b0001_0000);

    cur_req = "R1";
    #0.5 dn_n = 1'b0;
    cyc(2);
    check("R1", 8'b0001_0000);
    cyc(1);
    check("R1", 8'b0000_1000);

    cur_req = "R6";
    cyc(12);
    check("R6", 8'b0000_1000);
    #0.5 dn_n = 1'b1;
    cyc(6);
    check("R6", 8'b0000_1000);

    cur_req = "R4";
    press(0, 1, 4);
    check("R4", 8'b0001_0000);

    cur_req = "R3";
    press(1, 0, 3);
    check("R3", 8'b0000_1000);
    press(1, 0, 1);
    press(1, 0, 2);
    press(1, 0, 5);
    check("R3", 8'b0000_0001);

    cur_req = "R7";
    press(1, 0, 3);
    check("R7", 8'b0000_0001);

    cur_req = "R4";
    for (int i = 0; i < 7; i++) press(0, 1, 2);
    check("R4", 8'b1000_0000);

    cur_req = "R7";
    press(0, 1, 3);
    check("R7", 8'b1000_0000);

    cur_req = "R5";
    press(1, 0, 2);
    check("R5", 8'b0100_0000);
    press(1, 1, 4);
    check("R5", 8'b0100_0000);

    cur_req = "R8";
    @(negedge clk); #0.5;
    rst_n = 1'b0; up_n = 1'b0;
    cyc(5);
    check("R8", 8'b0001_0000);
    #0.5 rst_n = 1'b1; up_n = 1'b1;
    cyc(6);
    check("R8", 8'b0001_0000);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule